// File: doc/BRIEF.md
# Snooping Shared-Bus Transaction Sequencer

This block is the central sequencer of a shared bus that links several cache controllers with one backing memory. Each controller raises a request carrying an operation, a block address and, for an eviction, the block data. The sequencer picks one requester at a time in rotating order, holds the grant for the whole transaction, and puts the address, operation and source index on the bus for one cycle so that every other controller can snoop it. One cycle later it collects the snoop replies: a wired-OR "held elsewhere" flag and a wired-OR "owned dirty" flag, each with the requester's own reply masked off.

A fetch for a read miss or a write miss starts its fixed-latency memory read in the broadcast cycle. If any other cache answers dirty, that read is dropped. The sequencer then writes the owner's block into memory and starts the requester's fetch again, so the requester gets the freshly written data. An upgrade only broadcasts and never touches memory. An eviction writes the requester's data into memory. Every transaction ends with a one-cycle done pulse to its requester, which carries the shared result and, for fetches, the block data.

The states are IDLE (waiting for a request), ADDR (broadcast), SNOOP (sample the replies), FETCH (finish the overlapped read), MEMWR (memory write for an eviction or a dirty flush), REFETCH (replayed read after a flush) and FIN (done pulse). The transitions are: IDLE to ADDR on any request; ADDR to SNOOP always; SNOOP to FIN for an upgrade, to MEMWR for an eviction or for a fetch that saw dirty, otherwise to FETCH; FETCH to FIN when the read completes; MEMWR to REFETCH after a flush or to FIN after an eviction; REFETCH to FIN when the read completes; FIN to IDLE always.

Top module: `snoop_bus_seq`

## Requirements
- R1: Grants rotate. After requester k has been served, the next grant goes to the first active requester found by searching upward from k+1 and wrapping round. The first search after reset starts at requester 0. At most one grant is active, and it stays unchanged from its first cycle until the done pulse.
- R2: In the first cycle of a grant, bus_valid is high for exactly one cycle and carries the requester's address, its operation code and its index on bus_src. Operation codes: 0 read miss, 1 write miss, 2 upgrade, 3 eviction write-back.
- R3: Snoop replies are taken only in the cycle right after the broadcast. The requester's own snp_shared and snp_dirty bits are ignored, and replies given only during the broadcast cycle have no effect.
- R4: rsp_shared, which is valid with done, is high when any other cache replied shared, or when a fetch saw dirty from another cache.
- R5: A read miss with no dirty reply ends with done exactly MEM_LAT cycles after the grant appears. It returns the memory word at the address, and memory holds zero after reset.
- R6: A dirty reply to a fetch drops the read. The owner's snp_data lane is written to memory, and the fetch is then repeated. Done comes 2+2*MEM_LAT cycles after the grant, with the owner's data, and later reads return that data.
- R7: An upgrade ends with done 2 cycles after the grant. It ignores dirty replies and leaves memory unchanged.
- R8: An eviction writes the requester's req_wdata to memory and ends with done 2+MEM_LAT cycles after the grant. A dirty reply does not change its timing.
- R9: After reset, gnt, done and bus_valid are low. done is a one-cycle pulse and is given only to the granted requester.
- R10: A write miss follows the same sequence as a read miss, with the same timing and the same dirty replay, and broadcasts code 1 so that snoopers can tell it apart from a read miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | N | Request line per cache, held until done |
| req_op | input | 2*N | Operation code per cache |
| req_addr | input | AW*N | Block address per cache |
| req_wdata | input | DW*N | Eviction data per cache |
| gnt | output | N | One-hot bus grant |
| done | output | N | One-cycle end-of-transaction pulse |
| rsp_shared | output | 1 | Shared result, valid with done |
| rsp_data | output | DW | Fetched block, valid with done |
| bus_valid | output | 1 | Broadcast strobe |
| bus_op | output | 2 | Broadcast operation code |
| bus_addr | output | AW | Broadcast block address |
| bus_src | output | $clog2(N) | Broadcast requester index |
| snp_shared | input | N | Per-cache "held" reply |
| snp_dirty | input | N | Per-cache "owned dirty" reply |
| snp_data | input | DW*N | Per-cache flush data, sampled with dirty |

## Verification
The bench builds the block with four requesters, a 4-bit address, 16-bit data and a memory latency of 4. With four requesters, a full rotation of the arbiter and a wrap-around of its search fit in one scenario. With a latency of 4, the fetch overlapped with the broadcast and snoop cycles is clearly shorter than the flush-and-replay path (4 against 10 cycles), so a missing abort or a missing replay shows up in the done timing. The 16-entry memory keeps the values left by evictions and flushes in view, so later reads can check them.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_RDX  = 2'd1,
        OP_UPG  = 2'd2,
        OP_WB   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SNOOP,
        ST_FETCH,
        ST_MEMWR,
        ST_REFETCH,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/snp_rr_arb.sv
module snp_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] win
);
    logic [IW-1:0] cand;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        cand = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IW'((int'(last) + k) % N);
            if (!any && req[cand]) begin
                any = 1'b1;
                win = cand;
            end
        end
    end
endmodule

// File: rtl/snp_mem.sv
module snp_mem #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/snoop_bus_seq.sv
module snoop_bus_seq
    import snp_pkg::*;
#(
    parameter int N       = 4,
    parameter int AW      = 4,
    parameter int DW      = 16,
    parameter int MEM_LAT = 4,
    localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [2*N-1:0]  req_op,
    input  logic [AW*N-1:0] req_addr,
    input  logic [DW*N-1:0] req_wdata,
    output logic [N-1:0]    gnt,
    output logic [N-1:0]    done,
    output logic            rsp_shared,
    output logic [DW-1:0]   rsp_data,
    output logic            bus_valid,
    output logic [1:0]      bus_op,
    output logic [AW-1:0]   bus_addr,
    output logic [IW-1:0]   bus_src,
    input  logic [N-1:0]    snp_shared,
    input  logic [N-1:0]    snp_dirty,
    input  logic [DW*N-1:0] snp_data
);
    // Memory latency counter: counts from the broadcast cycle for an
    // overlapped fetch, from zero for a write or a replayed fetch.
    localparam int CW = $clog2(MEM_LAT) + 1;
    localparam logic [CW-1:0] LAST = CW'(MEM_LAT - 1);

    seq_state_e    state, nxt;
    logic [IW-1:0] cur_id, last_id, arb_win, own_sel;
    bus_op_e       cur_op;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] wbuf, rdata_q, mem_rdata;
    logic [CW-1:0] cnt;
    logic          replay, shared_q, arb_any, mem_we, is_fetch;
    logic [N-1:0]  own_mask, shared_vec, dirty_vec;

    snp_rr_arb #(.N(N)) u_arb (
        .req  (req),
        .last (last_id),
        .any  (arb_any),
        .win  (arb_win)
    );

    snp_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (cur_addr),
        .wdata (wbuf),
        .raddr (cur_addr),
        .rdata (mem_rdata)
    );

    assign own_mask   = N'(1) << cur_id;
    assign shared_vec = snp_shared & ~own_mask;
    assign dirty_vec  = snp_dirty & ~own_mask;
    assign is_fetch   = (cur_op == OP_READ) || (cur_op == OP_RDX);
    assign mem_we     = (state == ST_MEMWR) && (cnt == LAST);

    // Lowest-index dirty responder supplies the flush data.
    always_comb begin
        own_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (dirty_vec[i]) own_sel = IW'(i);
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (arb_any) nxt = ST_ADDR;
            ST_ADDR:    nxt = ST_SNOOP;
            ST_SNOOP: begin
                if (cur_op == OP_UPG)                 nxt = ST_FIN;
                else if (cur_op == OP_WB)             nxt = ST_MEMWR;
                else if (|dirty_vec)                  nxt = ST_MEMWR;
                else                                  nxt = ST_FETCH;
            end
            ST_FETCH:   if (cnt == LAST) nxt = ST_FIN;
            ST_MEMWR:   if (cnt == LAST) nxt = replay ? ST_REFETCH : ST_FIN;
            ST_REFETCH: if (cnt == LAST) nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_id   <= '0;
            last_id  <= IW'(N - 1);
            cur_op   <= OP_READ;
            cur_addr <= '0;
            wbuf     <= '0;
            rdata_q  <= '0;
            replay   <= 1'b0;
            shared_q <= 1'b0;
            cnt      <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (arb_any) begin
                        cur_id   <= arb_win;
                        last_id  <= arb_win;
                        cur_op   <= bus_op_e'(req_op[32'(arb_win) * 2 +: 2]);
                        cur_addr <= req_addr[32'(arb_win) * AW +: AW];
                        wbuf     <= req_wdata[32'(arb_win) * DW +: DW];
                        replay   <= 1'b0;
                    end
                end
                ST_SNOOP: begin
                    shared_q <= (|shared_vec) || (is_fetch && (|dirty_vec));
                    if (is_fetch && (|dirty_vec)) begin
                        replay <= 1'b1;
                        wbuf   <= snp_data[32'(own_sel) * DW +: DW];
                    end
                end
                ST_FETCH, ST_REFETCH: begin
                    if (cnt == LAST) rdata_q <= mem_rdata;
                end
                default: ;
            endcase
            if ((nxt != state) &&
                (nxt == ST_ADDR || nxt == ST_MEMWR || nxt == ST_REFETCH))
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        gnt        = (state != ST_IDLE) ? own_mask : '0;
        done       = (state == ST_FIN) ? own_mask : '0;
        bus_valid  = (state == ST_ADDR);
        bus_op     = cur_op;
        bus_addr   = cur_addr;
        bus_src    = cur_id;
        rsp_shared = shared_q;
        rsp_data   = rdata_q;
    end
endmodule

// File: rtl/snoop_bus_seq_chk.sv
module snoop_bus_seq_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic [N-1:0] gnt,
    input logic [N-1:0] done,
    input logic         bus_valid,
    input logic [1:0]   bus_op
);
    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_gnt_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !(|done)) |=> (gnt == $past(gnt)));

    assert_gnt_to_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !$past(|gnt)) |-> (|(gnt & $past(req))));

    assert_bus_at_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !$past(|gnt)) |-> bus_valid);

    assert_bus_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !bus_valid);

    assert_upg_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_op == 2'd2) |-> ##2 (|done));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> !(|done));

    assert_done_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> (done == gnt));
endmodule

bind snoop_bus_seq snoop_bus_seq_chk #(.N(N)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .gnt       (gnt),
    .done      (done),
    .bus_valid (bus_valid),
    .bus_op    (bus_op)
);

// File: tb/test_snoop_bus_seq.sv
`timescale 1ns/1ps
module test_snoop_bus_seq;
    localparam int N   = 4;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int LAT = 4;
    localparam int IW  = 2;
    localparam int OPR = 0, OPX = 1, OPU = 2, OPW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    gnt, done;
    logic            rsp_shared, bus_valid;
    logic [DW-1:0]   rsp_data;
    logic [1:0]      bus_op;
    logic [AW-1:0]   bus_addr;
    logic [IW-1:0]   bus_src;
    logic [N-1:0]    snp_shared = '0;
    logic [N-1:0]    snp_dirty = '0;
    logic [DW*N-1:0] snp_data = '0;

    int n_chk = 0, n_fail = 0, last_gnt = N - 1, wd_cnt = 0;

    snoop_bus_seq #(.N(N), .AW(AW), .DW(DW), .MEM_LAT(LAT)) i_snoop_bus_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .gnt(gnt), .done(done), .rsp_shared(rsp_shared),
        .rsp_data(rsp_data), .bus_valid(bus_valid), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_src(bus_src), .snp_shared(snp_shared),
        .snp_dirty(snp_dirty), .snp_data(snp_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One transaction; early=1 drives replies in the broadcast cycle only.
    task automatic txn(input int id, input int op, input int addr, input int wd,
                       input logic [N-1:0] sh, input logic [N-1:0] dy,
                       input int fdata, input bit early,
                       output int lat, output int data, output int shr);
        int cyc = 0, g = -1, arm = 0;
        @(negedge clk);
        req[id] = 1'b1;
        req_op[id*2 +: 2] = 2'(op);
        req_addr[id*AW +: AW] = AW'(addr);
        req_wdata[id*DW +: DW] = DW'(wd);
        for (int i = 0; i < N; i++) snp_data[i*DW +: DW] = DW'(fdata);
        lat = -1; data = -1; shr = -1;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (arm == 2) begin snp_shared = '0; snp_dirty = '0; arm = 0; end
            if (arm == 1) begin snp_shared = sh; snp_dirty = dy; arm = 2; end
            if (bus_valid) begin
                chk("R2 bus_op", int'(bus_op), op);
                chk("R2 bus_addr", int'(bus_addr), addr);
                chk("R2 bus_src", int'(bus_src), id);
                if (early) begin snp_shared = sh; snp_dirty = dy; arm = 2; end
                else arm = 1;
            end
            if (gnt[id] && g < 0) g = cyc;
            if (done[id]) begin
                lat = cyc - g; data = int'(rsp_data); shr = int'(rsp_shared);
                break;
            end
        end
        req[id] = 1'b0;
        snp_shared = '0; snp_dirty = '0;
        last_gnt = id;
    endtask

    task automatic t_reset();
        chk("R9 reset gnt", int'(gnt), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset bus_valid", int'(bus_valid), 0);
    endtask

    task automatic t_evict_and_read();
        int lat, d, s;
        txn(0, OPR, 7, 0, '0, '0, 0, 0, lat, d, s);
        chk("R5 reset memory zero", d, 0);
        chk("R5 read latency", lat, LAT);
        txn(0, OPW, 3, 'hA5A5, '0, '0, 0, 0, lat, d, s);
        chk("R8 evict latency", lat, 2 + LAT);
        txn(1, OPR, 3, 0, '0, '0, 0, 0, lat, d, s);
        chk("R5 read data", d, 'hA5A5);
        chk("R4 no sharer", s, 0);
        txn(0, OPW, 9, 'h0042, '0, 4'b0100, 'hDEAD, 0, lat, d, s);
        chk("R8 dirty ignored latency", lat, 2 + LAT);
        txn(2, OPR, 9, 0, '0, '0, 0, 0, lat, d, s);
        chk("R8 evict data kept", d, 'h0042);
    endtask

    task automatic t_snoop_mask();
        int lat, d, s;
        txn(2, OPR, 3, 0, 4'b0001, '0, 0, 0, lat, d, s);
        chk("R4 sharer reported", s, 1);
        txn(1, OPR, 3, 0, 4'b0010, '0, 0, 0, lat, d, s);
        chk("R3 own shared masked", s, 0);
        txn(1, OPR, 3, 0, '0, 4'b0010, 'h7777, 0, lat, d, s);
        chk("R3 own dirty masked latency", lat, LAT);
        chk("R3 own dirty masked data", d, 'hA5A5);
        txn(3, OPR, 3, 0, 4'b0001, 4'b0001, 'h5555, 1, lat, d, s);
        chk("R3 early reply ignored shared", s, 0);
        chk("R3 early reply ignored latency", lat, LAT);
    endtask

    task automatic t_dirty();
        int lat, d, s;
        txn(2, OPR, 5, 0, '0, 4'b1000, 'h1234, 0, lat, d, s);
        chk("R6 replay latency", lat, 2 + 2 * LAT);
        chk("R6 replay data", d, 'h1234);
        chk("R4 dirty counts as shared", s, 1);
        txn(0, OPR, 5, 0, '0, '0, 0, 0, lat, d, s);
        chk("R6 memory updated", d, 'h1234);
    endtask

    task automatic t_write_miss();
        int lat, d, s;
        txn(3, OPX, 3, 0, '0, '0, 0, 0, lat, d, s);
        chk("R10 write miss latency", lat, LAT);
        chk("R10 write miss data", d, 'hA5A5);
        txn(3, OPX, 3, 0, '0, 4'b0001, 'hBEEF, 0, lat, d, s);
        chk("R10 write miss replay latency", lat, 2 + 2 * LAT);
        chk("R10 write miss replay data", d, 'hBEEF);
    endtask

    task automatic t_upgrade();
        int lat, d, s;
        txn(1, OPU, 5, 'hFFFF, '0, 4'b0001, 'h9999, 0, lat, d, s);
        chk("R7 upgrade latency", lat, 2);
        txn(2, OPR, 5, 0, '0, '0, 0, 0, lat, d, s);
        chk("R7 memory unchanged", d, 'h1234);
    endtask

    task automatic t_round_robin();
        int order[N];
        int got = 0, fin = 0, cyc = 0;
        bit prev = 1'b0;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            req[i] = 1'b1;
            req_op[i*2 +: 2] = 2'(OPU);
            req_addr[i*AW +: AW] = AW'(i);
        end
        while (fin < N && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if ((|gnt) && !prev && got < N) begin
                for (int i = 0; i < N; i++) if (gnt[i]) order[got] = i;
                got++;
            end
            prev = |gnt;
            chk("R9 done only to granted", int'(done & ~gnt), 0);
            for (int i = 0; i < N; i++) if (done[i]) begin req[i] = 1'b0; fin++; end
        end
        chk("R1 grant count", got, N);
        for (int k = 0; k < N; k++)
            chk("R1 rotation order", order[k], (last_gnt + 1 + k) % N);
        last_gnt = order[N-1];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_evict_and_read();
        t_snoop_mask();
        t_dirty();
        t_write_miss();
        t_upgrade();
        t_round_robin();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule